// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit byte logical address into a physical address by reading two levels of translation entries from a word-addressed memory. The upper ten bits of the logical address select an entry in a one-page directory. The directory's frame number is held in a base input. That entry names the frame of a page table, and the next ten bits select the leaf entry there. The leaf's frame number joined to the low twelve offset bits gives the physical address. When the present bit is clear at either level, the walk stops and reports which level failed, along with the logical address that caused it.

On a successful walk the leaf entry's accessed bit is set. For a store the dirty bit is set as well. The updated leaf is written back to memory only when one of those bits actually changes. Only one translation is in flight at a time.

The request, response and memory-request channels use valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. Once the response is raised, it and all of its fields stay unchanged until `rsp_ready` accepts it. A memory request holds its address, write flag and data until `mem_req_ready` is seen. Read data comes back on `mem_rsp_valid` with no back-pressure, at any latency of one cycle or more. Writes get no response.

Top module: `xw_walker`

## Requirements
- R1: The first memory read of a walk uses word address {directory base[19:0], logical[31:22]}, which is the directory base plus the directory index shifted left by 2, expressed in words.
- R2: The second read uses word address {directory entry[31:12], logical[21:12]}.
- R3: If bit 0 (present) of the directory entry is 0, the response has rsp_fault=1 and rsp_level=0 (directory). No second read and no write are issued.
- R4: If bit 0 of the table entry is 0, the response has rsp_fault=1 and rsp_level=1 (table), and no write is issued.
- R5: On success rsp_fault=0 and rsp_paddr = {table entry[31:12], logical[11:0]}.
- R6: A load whose leaf has bit 5 (accessed) clear writes the leaf back to the address of R2 with bit 5 set and all other bits unchanged.
- R7: A store writes the leaf back with bit 5 and bit 6 (dirty) set whenever either was clear.
- R8: No write is issued when the required bits are already set (bit 5 for a load, bits 5 and 6 for a store).
- R9: rsp_vaddr returns the request's logical address. rsp_flags returns the low 12 bits of the leaf after update, or of the faulting entry on a fault. Bit 1 is read/write and bit 2 is user/supervisor, both reported unchanged.
- R10: req_ready is low from acceptance until the response is taken. rsp_valid with its fields, and mem_req_valid with its fields, hold steady while their ready input is low.
- R11: After reset req_ready=1, rsp_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical byte address |
| req_store | input | 1 | 1 = store access, 0 = load |
| dir_base | input | 20 | Frame number of the directory page (address bits 31:12) |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Present bit clear at some level |
| rsp_level | output | 1 | Level that faulted: 0 directory, 1 table |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_vaddr | output | 32 | Logical address of this result |
| rsp_flags | output | 12 | Flag bits of the leaf or faulting entry |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write-back of leaf entry |
| mem_req_addr | output | 30 | Word address |
| mem_req_wdata | output | 32 | Entry to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` for each accepted read, and never for a write or without an outstanding read. They also assume that `rsp_ready` is only sampled as meaningful while a result is offered. The bench memory model guarantees the first assumption. It issues a read reply two cycles after acceptance and counts reads and writes. Its request ready follows a fixed stall pattern, so every channel sees back-pressure. The response side holds `rsp_ready` low for several cycles in one scenario, to exercise the hold rules.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W_DEF  = 32;
  localparam int OFF_W_DEF = 12;
  localparam int IDX_W_DEF = 10;
  localparam int PTE_W_DEF = 32;
  // flag bit positions inside an entry
  localparam int FLAG_P_DEF = 0;
  localparam int FLAG_A_DEF = 5;
  localparam int FLAG_D_DEF = 6;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_DREQ  = 3'd1,
    W_DWAIT = 3'd2,
    W_TREQ  = 3'd3,
    W_TWAIT = 3'd4,
    W_WBACK = 3'd5,
    W_RESP  = 3'd6
  } walk_state_t;
endpackage

// File: rtl/xw_index_gen.sv
module xw_index_gen #(
  parameter int IDX_W = 10,
  parameter int FRM_W = 20,
  localparam int VPN_W = 2 * IDX_W,
  localparam int WA_W  = FRM_W + IDX_W
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [FRM_W-1:0] root_frame,
  input  logic [FRM_W-1:0] leaf_frame,
  input  logic             sel_leaf,
  output logic [WA_W-1:0]  word_addr
);
  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  assign dir_idx = vpn[VPN_W-1 -: IDX_W];
  assign tbl_idx = vpn[IDX_W-1:0];

  // entries are 4 bytes: frame base + index*4, in words = {frame, index}
  always_comb begin
    if (sel_leaf) word_addr = {leaf_frame, tbl_idx};
    else          word_addr = {root_frame, dir_idx};
  end
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval #(
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int FLAG_P = 0,
  parameter int FLAG_A = 5,
  parameter int FLAG_D = 6,
  localparam int FRM_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_store,
  output logic             present,
  output logic [FRM_W-1:0] frame,
  output logic [PTE_W-1:0] upd_entry,
  output logic             need_wb
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask          = '0;
    set_mask[FLAG_A]  = 1'b1;
    set_mask[FLAG_D]  = is_store;
  end

  assign present   = entry[FLAG_P];
  assign frame     = entry[PTE_W-1:OFF_W];
  assign upd_entry = entry | set_mask;
  assign need_wb   = (entry & set_mask) != set_mask;
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
  import xw_pkg::*;
#(
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int FLAG_P = 0,
  localparam int FRM_W = PTE_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] rd_raw,
  input  logic             rd_present,
  input  logic [FRM_W-1:0] rd_frame,
  input  logic [PTE_W-1:0] rd_upd,
  input  logic             rd_need_wb,
  input  logic             rsp_ready,
  output walk_state_t      state,
  output logic [FRM_W-1:0] tbl_frame_q,
  output logic [PTE_W-1:0] ent_q,
  output logic             fault_q,
  output logic             level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= W_IDLE;
      tbl_frame_q <= '0;
      ent_q       <= '0;
      fault_q     <= 1'b0;
      level_q     <= 1'b0;
    end else begin
      unique case (state)
        W_IDLE:  if (req_fire) state <= W_DREQ;
        W_DREQ:  if (mem_req_ready) state <= W_DWAIT;
        W_DWAIT: if (mem_rsp_valid) begin
          if (!rd_present) begin
            ent_q   <= rd_raw;
            fault_q <= 1'b1;
            level_q <= 1'b0;
            state   <= W_RESP;
          end else begin
            tbl_frame_q <= rd_frame;
            state       <= W_TREQ;
          end
        end
        W_TREQ:  if (mem_req_ready) state <= W_TWAIT;
        W_TWAIT: if (mem_rsp_valid) begin
          level_q <= 1'b1;
          if (!rd_present) begin
            ent_q   <= rd_raw;
            fault_q <= 1'b1;
            state   <= W_RESP;
          end else begin
            ent_q   <= rd_upd;
            fault_q <= 1'b0;
            state   <= rd_need_wb ? W_WBACK : W_RESP;
          end
        end
        W_WBACK: if (mem_req_ready) state <= W_RESP;
        W_RESP:  if (rsp_ready) state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

  // R3 R4: a fault result always carries an entry whose present bit is clear
  assert_fault_not_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_RESP && fault_q) |-> !ent_q[FLAG_P]);

  // R10: a new request is only taken while idle
  assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (state == W_IDLE));
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
#(
  parameter int VA_W   = VA_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int IDX_W  = IDX_W_DEF,
  parameter int PTE_W  = PTE_W_DEF,
  parameter int FLAG_P = FLAG_P_DEF,
  parameter int FLAG_A = FLAG_A_DEF,
  parameter int FLAG_D = FLAG_D_DEF,
  localparam int FRM_W = VA_W - OFF_W,
  localparam int VPN_W = 2 * IDX_W,
  localparam int WA_W  = FRM_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic [FRM_W-1:0] dir_base,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic             rsp_level,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [VA_W-1:0]  rsp_vaddr,
  output logic [OFF_W-1:0] rsp_flags,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [WA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata
);
  walk_state_t      state;
  logic [VA_W-1:0]  va_q;
  logic             store_q;
  logic [FRM_W-1:0] base_q;
  logic [FRM_W-1:0] tbl_frame_q;
  logic [PTE_W-1:0] ent_q;
  logic             fault_q;
  logic             level_q;
  logic             req_fire;
  logic             rd_present;
  logic [FRM_W-1:0] rd_frame;
  logic [PTE_W-1:0] rd_upd;
  logic             rd_need_wb;

  assign req_ready = (state == W_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      store_q <= 1'b0;
      base_q  <= '0;
    end else if (req_fire) begin
      va_q    <= req_vaddr;
      store_q <= req_store;
      base_q  <= dir_base;
    end
  end

  xw_index_gen #(.IDX_W(IDX_W), .FRM_W(FRM_W)) u_idx (
    .vpn        (va_q[VA_W-1 -: VPN_W]),
    .root_frame (base_q),
    .leaf_frame (tbl_frame_q),
    .sel_leaf   (state != W_DREQ),
    .word_addr  (mem_req_addr)
  );

  xw_entry_eval #(
    .PTE_W(PTE_W), .OFF_W(OFF_W),
    .FLAG_P(FLAG_P), .FLAG_A(FLAG_A), .FLAG_D(FLAG_D)
  ) u_eval (
    .entry     (mem_rsp_rdata),
    .is_store  (store_q),
    .present   (rd_present),
    .frame     (rd_frame),
    .upd_entry (rd_upd),
    .need_wb   (rd_need_wb)
  );

  xw_walk_ctrl #(.PTE_W(PTE_W), .OFF_W(OFF_W), .FLAG_P(FLAG_P)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rd_raw        (mem_rsp_rdata),
    .rd_present    (rd_present),
    .rd_frame      (rd_frame),
    .rd_upd        (rd_upd),
    .rd_need_wb    (rd_need_wb),
    .rsp_ready     (rsp_ready),
    .state         (state),
    .tbl_frame_q   (tbl_frame_q),
    .ent_q         (ent_q),
    .fault_q       (fault_q),
    .level_q       (level_q)
  );

  assign mem_req_valid = (state == W_DREQ) || (state == W_TREQ) || (state == W_WBACK);
  assign mem_req_write = (state == W_WBACK);
  assign mem_req_wdata = ent_q;

  assign rsp_valid = (state == W_RESP);
  assign rsp_fault = fault_q;
  assign rsp_level = level_q;
  assign rsp_vaddr = va_q;
  assign rsp_flags = ent_q[OFF_W-1:0];
  assign rsp_paddr = fault_q ? '0 : {ent_q[PTE_W-1:OFF_W], va_q[OFF_W-1:0]};

  // R10: result held under back-pressure
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_flags)
                                   && $stable(rsp_fault) && $stable(rsp_vaddr)));

  // R10: memory request held until taken
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                           && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R10: no new request accepted while a translation is outstanding
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R6: every write-back carries present and accessed bits
  assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[FLAG_P] && mem_req_wdata[FLAG_A]));

  // R7: a store's write-back is marked dirty
  assert_store_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && store_q) |-> mem_req_wdata[FLAG_D]);

  // R5 R6: a successful result reports an accessed, present leaf
  assert_ok_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_flags[FLAG_P] && rsp_flags[FLAG_A]));
endmodule

// File: tb/sim_xw_walker.sv
`timescale 1ns/1ps
module sim_xw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic [19:0] dir_base = 20'h1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic        rsp_level;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_vaddr;
  logic [11:0] rsp_flags;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [29:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  xw_walker u0 (.*);

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  logic [3:0]  stall_cnt = '0;
  logic        p_v = 1'b0;
  logic [11:0] p_a = '0;
  int          rd_cnt = 0, wr_cnt = 0, oob_cnt = 0;
  logic [29:0] rd_last = '0, rd_prev = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bd_we = 1'b0;
  logic [11:0] bd_a = '0;
  logic [31:0] bd_d = '0;

  assign mem_req_ready = (stall_cnt[1:0] != 2'd3);

  always @(posedge clk) begin
    stall_cnt     <= stall_cnt + 4'd1;
    p_v           <= 1'b0;
    mem_rsp_valid <= p_v;
    mem_rsp_rdata <= p_v ? mem[p_a] : 32'h0;
    if (bd_we) mem[bd_a] <= bd_d;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr[29:12] != 0) oob_cnt <= oob_cnt + 1;
      if (mem_req_write) begin
        mem[mem_req_addr[11:0]] <= mem_req_wdata;
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_req_addr;
        wr_data <= mem_req_wdata;
      end else begin
        p_v     <= 1'b1;
        p_a     <= mem_req_addr[11:0];
        rd_cnt  <= rd_cnt + 1;
        rd_prev <= rd_last;
        rd_last <= mem_req_addr;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_bad = 0;
  logic        r_fault, r_level;
  logic [31:0] r_paddr, r_vaddr;
  logic [11:0] r_flags;
  int          d_rd, d_wr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_a = a; bd_d = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  // one translation; hold_cyc cycles of response back-pressure
  task automatic xlat(input logic [31:0] va, input logic st, input int hold_cyc);
    int rd0, wr0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_fault = rsp_fault; r_level = rsp_level; r_paddr = rsp_paddr;
    r_vaddr = rsp_vaddr; r_flags = rsp_flags;
    for (int i = 0; i < hold_cyc; i++) begin
      @(negedge clk);
      check("R10 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
      check("R10 paddr held", rsp_paddr, r_paddr);
      check("R10 req_ready low while busy", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check("R11 req_ready", {31'd0, req_ready}, 32'd1);
    check("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_load_first;
    xlat(32'h00C05123, 1'b0, 0);
    check("R1 directory read addr", {2'b0, rd_prev}, 32'h403);
    check("R2 table read addr", {2'b0, rd_last}, 32'h805);
    check("R5 fault", {31'd0, r_fault}, 32'd0);
    check("R5 paddr", r_paddr, 32'hABCDE123);
    check("R9 vaddr", r_vaddr, 32'h00C05123);
    check("R9 flags", {20'd0, r_flags}, 32'h023);
    check("R6 one write", d_wr, 1);
    check("R6 wb addr", {2'b0, wr_addr}, 32'h805);
    check("R6 wb data", wr_data, 32'hABCDE023);
  endtask

  task automatic t_store_dirty;
    xlat(32'h00C05FF0, 1'b1, 0);
    check("R7 one write", d_wr, 1);
    check("R7 wb data", wr_data, 32'hABCDE063);
    check("R5 paddr store", r_paddr, 32'hABCDEFF0);
  endtask

  task automatic t_no_wb;
    xlat(32'h00C05004, 1'b0, 0);
    check("R8 load no write", d_wr, 0);
    check("R8 load two reads", d_rd, 2);
    check("R9 flags kept", {20'd0, r_flags}, 32'h063);
    xlat(32'h00C05008, 1'b1, 0);
    check("R8 store no write", d_wr, 0);
  endtask

  task automatic t_dir_fault;
    xlat(32'h01C00456, 1'b1, 0);
    check("R3 fault", {31'd0, r_fault}, 32'd1);
    check("R3 level", {31'd0, r_level}, 32'd0);
    check("R3 one read", d_rd, 1);
    check("R3 no write", d_wr, 0);
    check("R9 fault vaddr", r_vaddr, 32'h01C00456);
    check("R9 fault flags", {20'd0, r_flags}, 32'h000);
  endtask

  task automatic t_tbl_fault;
    xlat(32'h023FFFFF, 1'b1, 0);
    check("R4 fault", {31'd0, r_fault}, 32'd1);
    check("R4 level", {31'd0, r_level}, 32'd1);
    check("R4 two reads", d_rd, 2);
    check("R4 no write", d_wr, 0);
    check("R2 read addr max index", {2'b0, rd_last}, 32'hFFF);
    check("R9 flags user bit", {20'd0, r_flags}, 32'h004);
  endtask

  task automatic t_edge_backpressure;
    xlat(32'hFFC00FFF, 1'b1, 4);
    check("R1 read addr max dir index", {2'b0, rd_prev}, 32'h7FF);
    check("R5 paddr all ones", r_paddr, 32'hFFFFFFFF);
    check("R7 wb data edge", wr_data, 32'hFFFFF061);
    check("R10 idle after take", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    poke(12'd1027, 32'h00002001);  // dir[3]    -> table frame 2
    poke(12'd2053, 32'hABCDE003);  // tbl2[5]   P|RW
    poke(12'd1031, 32'h00003000);  // dir[7]    not present
    poke(12'd1032, 32'h00003007);  // dir[8]    -> table frame 3
    poke(12'd4095, 32'h12345004);  // tbl3[1023] not present, US
    poke(12'd2047, 32'h00002001);  // dir[1023] -> table frame 2
    poke(12'd2048, 32'hFFFFF001);  // tbl2[0]
    t_load_first();
    t_store_dirty();
    t_no_wb();
    t_dir_fault();
    t_tbl_fault();
    t_edge_backpressure();
    check("R1 accesses in range", oob_cnt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule